// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a logical address, given as a segment number and an offset inside that segment, into a physical address. An on-chip table holds one entry per segment. Each entry has a starting physical address, a segment length, a valid flag and read, write and execute rights. A separate register says how many segments the current program may use. A lookup either returns the physical address or a trap code that names the first check that failed.

The checks run in a fixed order. First the segment number is compared with the length register. Then the entry's valid flag is checked, then the rights for the requested access, and then the offset against the segment length. The base is added only when all four checks pass. The checks and the addition are combinational. A single output register holds the result, so each lookup answers one cycle after it is presented.

Software, or a higher-level controller, fills the table and the length register through a configuration port. A write takes effect for lookups presented from the next clock edge on.

Top module: `seg_xlate_unit`

## Requirements
- R1: During and after synchronous reset, `rsp_valid`, `rsp_trap` and `rsp_paddr` are 0. The length register is cleared and every entry is marked invalid, so any lookup after reset traps with code 1 until the unit is configured.
- R2: A lookup sampled with `req_valid` high at a rising edge produces `rsp_valid`=1 and its result right after that edge. After an edge with `req_valid` low, `rsp_valid`, `rsp_trap` and `rsp_paddr` are all 0.
- R3: If the segment number is not below the length register, the trap code is 1 (bad segment number). This check wins over every other check.
- R4: If the segment number is legal but the entry's valid flag is 0, the trap code is 2 (invalid segment).
- R5: Access kind `req_kind` is encoded 0 read, 1 write, 2 execute, 3 reserved. Permission bits `cfg_perm` are bit 0 read, bit 1 write, bit 2 execute. Kind 3 is never allowed. A valid entry without the requested right traps with code 3 (protection), even when the offset is also out of range.
- R6: If the first three checks pass and the offset is not less than the entry's limit, the trap code is 4 (limit exceeded).
- R7: When all checks pass, the trap code is 0 and `rsp_paddr` is base plus offset, kept to the low `PADDR_W` bits.
- R8: Whenever the trap code is not 0, `rsp_paddr` is 0.
- R9: A table write or a length write at a rising edge affects lookups sampled at the next edge and later. A lookup sampled at the same edge as the write sees the old contents.
- R10: The length register accepts values 0 through `SEG_COUNT`. A length of `SEG_COUNT` makes every segment number legal, and a length of 0 makes every segment number illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_entry_we | input | 1 | Write one table entry |
| cfg_idx | input | SEG_W | Entry index to write |
| cfg_base | input | PADDR_W | Segment start physical address |
| cfg_limit | input | OFFSET_W+1 | Segment length |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_perm | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cfg_len_we | input | 1 | Write the length register |
| cfg_len | input | SEG_W+1 | Number of usable segments |
| req_valid | input | 1 | Lookup strobe |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFFSET_W | Offset inside the segment |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | PADDR_W | Physical address, 0 on a trap |
| rsp_trap | output | 3 | Trap code 0 to 4 |

## Verification
The bench targets the priority edges. It sends a request that fails several checks at once, for example a wrong right combined with an out-of-range offset, or an illegal number that points at a valid entry. A design that reorders the checks would return the lower-priority code. It probes the limit at offset equal to limit and at limit minus one, where an off-by-one compare would wrongly pass or wrongly trap. It also probes the reserved access kind. It issues a table write and a lookup of the same entry in the same cycle. A design that bypasses the write would answer with the new entry one cycle early. Finally it probes a length of 0 and of the full table, and uses a base near the top of the physical range so that a wrong sum width becomes visible.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    TRAP_NONE    = 3'd0,
    TRAP_SEGNUM  = 3'd1,
    TRAP_INVALID = 3'd2,
    TRAP_PROT    = 3'd3,
    TRAP_LIMIT   = 3'd4
  } trap_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W    = 3;
  localparam int PERM_RD   = 0;
  localparam int PERM_WR   = 1;
  localparam int PERM_EX   = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_COUNT = 16,
  parameter int SEG_W     = 4,
  parameter int BASE_W    = 20,
  parameter int LIMIT_W   = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SEG_W-1:0]     wr_idx,
  input  logic [BASE_W-1:0]    wr_base,
  input  logic [LIMIT_W-1:0]   wr_limit,
  input  logic                 wr_valid,
  input  logic [2:0]           wr_perm,
  input  logic                 len_we,
  input  logic [SEG_W:0]       len_in,
  input  logic [SEG_W-1:0]     rd_idx,
  output logic [BASE_W-1:0]    rd_base,
  output logic [LIMIT_W-1:0]   rd_limit,
  output logic                 rd_valid,
  output logic [2:0]           rd_perm,
  output logic [SEG_W:0]       len_q
);

  // Payload storage carries no reset, so it maps onto distributed RAM.
  logic [BASE_W-1:0]  base_mem  [SEG_COUNT];
  logic [LIMIT_W-1:0] limit_mem [SEG_COUNT];
  logic [2:0]         perm_mem  [SEG_COUNT];
  logic [SEG_COUNT-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_mem[wr_idx]  <= wr_base;
      limit_mem[wr_idx] <= wr_limit;
      perm_mem[wr_idx]  <= wr_perm;
    end
  end

  // Valid flags and the length register are reset, so every lookup traps until the table is loaded.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      len_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_idx] <= wr_valid;
      if (len_we) len_q <= len_in;
    end
  end

  assign rd_base  = base_mem[rd_idx];
  assign rd_limit = limit_mem[rd_idx];
  assign rd_perm  = perm_mem[rd_idx];
  assign rd_valid = vld_q[rd_idx];

  AST_ENTRY_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_valid))); // R9

  AST_LEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    len_we |=> (len_q == $past(len_in))); // R10

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W    = 4,
  parameter int OFFSET_W = 12,
  parameter int BASE_W   = 20,
  parameter int LIMIT_W  = 13
) (
  input  logic [SEG_W-1:0]    seg,
  input  logic [OFFSET_W-1:0] off,
  input  logic [1:0]          kind,
  input  logic [SEG_W:0]      len,
  input  logic                e_valid,
  input  logic [2:0]          e_perm,
  input  logic [BASE_W-1:0]   e_base,
  input  logic [LIMIT_W-1:0]  e_limit,
  output trap_e               trap,
  output logic [BASE_W-1:0]   paddr
);

  localparam int PAD_W = BASE_W - OFFSET_W;

  logic seg_ok;
  logic perm_ok;
  logic in_bounds;

  assign seg_ok    = ({1'b0, seg} < len);
  assign in_bounds = ({1'b0, off} < e_limit);

  always_comb begin
    unique case (acc_e'(kind))
      ACC_READ:  perm_ok = e_perm[PERM_RD];
      ACC_WRITE: perm_ok = e_perm[PERM_WR];
      ACC_EXEC:  perm_ok = e_perm[PERM_EX];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!seg_ok)         trap = TRAP_SEGNUM;
    else if (!e_valid)   trap = TRAP_INVALID;
    else if (!perm_ok)   trap = TRAP_PROT;
    else if (!in_bounds) trap = TRAP_LIMIT;
    else                 trap = TRAP_NONE;
  end

  assign paddr = (trap == TRAP_NONE) ? (e_base + {{PAD_W{1'b0}}, off}) : '0;

  always_comb begin
    if (trap == TRAP_LIMIT)
      AST_LIMIT_AFTER_PERM: assert (perm_ok && e_valid); // R5
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 16,
  parameter int OFFSET_W  = 12,
  parameter int PADDR_W   = 20,
  localparam int SEG_W    = $clog2(SEG_COUNT),
  localparam int LIMIT_W  = OFFSET_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_entry_we,
  input  logic [SEG_W-1:0]     cfg_idx,
  input  logic [PADDR_W-1:0]   cfg_base,
  input  logic [LIMIT_W-1:0]   cfg_limit,
  input  logic                 cfg_valid,
  input  logic [2:0]           cfg_perm,
  input  logic                 cfg_len_we,
  input  logic [SEG_W:0]       cfg_len,
  input  logic                 req_valid,
  input  logic [SEG_W-1:0]     req_seg,
  input  logic [OFFSET_W-1:0]  req_off,
  input  logic [1:0]           req_kind,
  output logic                 rsp_valid,
  output logic [PADDR_W-1:0]   rsp_paddr,
  output logic [2:0]           rsp_trap
);

  logic [PADDR_W-1:0] e_base;
  logic [LIMIT_W-1:0] e_limit;
  logic               e_valid;
  logic [2:0]         e_perm;
  logic [SEG_W:0]     len_q;
  trap_e              chk_trap;
  logic [PADDR_W-1:0] chk_paddr;

  seg_table #(
    .SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .BASE_W(PADDR_W), .LIMIT_W(LIMIT_W)
  ) tbl_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_entry_we), .wr_idx(cfg_idx), .wr_base(cfg_base),
    .wr_limit(cfg_limit), .wr_valid(cfg_valid), .wr_perm(cfg_perm),
    .len_we(cfg_len_we), .len_in(cfg_len),
    .rd_idx(req_seg),
    .rd_base(e_base), .rd_limit(e_limit), .rd_valid(e_valid), .rd_perm(e_perm),
    .len_q(len_q)
  );

  seg_check #(
    .SEG_W(SEG_W), .OFFSET_W(OFFSET_W), .BASE_W(PADDR_W), .LIMIT_W(LIMIT_W)
  ) chk_i (
    .seg(req_seg), .off(req_off), .kind(req_kind), .len(len_q),
    .e_valid(e_valid), .e_perm(e_perm), .e_base(e_base), .e_limit(e_limit),
    .trap(chk_trap), .paddr(chk_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_trap  <= req_valid ? 3'(chk_trap) : 3'd0;
      rsp_paddr <= req_valid ? chk_paddr    : '0;
    end
  end

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_trap == 3'd0 && rsp_paddr == '0)); // R2

  AST_SEGNUM_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ({1'b0, req_seg} >= len_q)) |=> (rsp_trap == 3'd1)); // R3

  AST_TRAP_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_trap != 3'd0) |-> (rsp_paddr == '0)); // R8

  AST_TRAP_CODE_RANGE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_trap <= 3'd4)); // R7

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb_top;

  localparam int SEG_COUNT = 16;
  localparam int OFFSET_W  = 12;
  localparam int PADDR_W   = 20;
  localparam int SEG_W     = $clog2(SEG_COUNT);
  localparam int LIMIT_W   = OFFSET_W + 1;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cfg_entry_we = 0;
  logic [SEG_W-1:0]    cfg_idx = '0;
  logic [PADDR_W-1:0]  cfg_base = '0;
  logic [LIMIT_W-1:0]  cfg_limit = '0;
  logic                cfg_valid = 0;
  logic [2:0]          cfg_perm = '0;
  logic                cfg_len_we = 0;
  logic [SEG_W:0]      cfg_len = '0;
  logic                req_valid = 0;
  logic [SEG_W-1:0]    req_seg = '0;
  logic [OFFSET_W-1:0] req_off = '0;
  logic [1:0]          req_kind = '0;
  logic                rsp_valid;
  logic [PADDR_W-1:0]  rsp_paddr;
  logic [2:0]          rsp_trap;

  seg_xlate_unit #(.SEG_COUNT(SEG_COUNT), .OFFSET_W(OFFSET_W), .PADDR_W(PADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_entry_we(cfg_entry_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_valid(cfg_valid), .cfg_perm(cfg_perm),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit armed = 0;
  bit done  = 0;

  // Behavioural reference model
  logic [PADDR_W-1:0] m_base [SEG_COUNT];
  int                 m_lim  [SEG_COUNT];
  bit                 m_vld  [SEG_COUNT];
  bit [2:0]           m_perm [SEG_COUNT];
  int                 m_len;
  bit                 exp_v;
  int                 exp_tr;
  logic [PADDR_W-1:0] exp_pa;
  string              exp_tag;

  always @(posedge clk) begin
    if (rst) begin
      exp_v = 0; exp_tr = 0; exp_pa = '0; exp_tag = "R1";
      m_len = 0;
      for (int i = 0; i < SEG_COUNT; i++) m_vld[i] = 0;
    end else begin
      if (req_valid) begin
        bit ok;
        exp_v = 1; exp_pa = '0;
        case (req_kind)
          2'd0: ok = m_perm[req_seg][0];
          2'd1: ok = m_perm[req_seg][1];
          2'd2: ok = m_perm[req_seg][2];
          default: ok = 0;
        endcase
        if (int'(req_seg) >= m_len)          begin exp_tr = 1; exp_tag = "R3"; end
        else if (!m_vld[req_seg])            begin exp_tr = 2; exp_tag = "R4"; end
        else if (!ok)                        begin exp_tr = 3; exp_tag = "R5"; end
        else if (int'(req_off) >= m_lim[req_seg]) begin exp_tr = 4; exp_tag = "R6"; end
        else begin
          exp_tr = 0; exp_tag = "R7";
          exp_pa = m_base[req_seg] + PADDR_W'(req_off);
        end
      end else begin
        exp_v = 0; exp_tr = 0; exp_pa = '0; exp_tag = "R2";
      end
      // writes land after the lookup of this edge (R9)
      if (cfg_entry_we) begin
        m_base[cfg_idx] = cfg_base;
        m_lim[cfg_idx]  = int'(cfg_limit);
        m_vld[cfg_idx]  = cfg_valid;
        m_perm[cfg_idx] = cfg_perm;
      end
      if (cfg_len_we) m_len = int'(cfg_len);
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      total++;
      if (rsp_valid !== exp_v || int'(rsp_trap) != exp_tr || rsp_paddr !== exp_pa) begin
        bad++;
        $display("FAIL %s: got valid=%0d trap=%0d paddr=%h, expected valid=%0d trap=%0d paddr=%h",
                 exp_tag, rsp_valid, rsp_trap, rsp_paddr, exp_v, exp_tr, exp_pa);
      end
    end
  end

  task automatic clear_strobes();
    cfg_entry_we = 0; cfg_len_we = 0; req_valid = 0;
  endtask

  task automatic put_entry(int idx, int base, int lim, bit vld, int perm);
    cfg_entry_we = 1; cfg_idx = SEG_W'(idx); cfg_base = PADDR_W'(base);
    cfg_limit = LIMIT_W'(lim); cfg_valid = vld; cfg_perm = 3'(perm);
  endtask

  task automatic put_len(int n);
    cfg_len_we = 1; cfg_len = (SEG_W+1)'(n);
  endtask

  task automatic put_req(int seg, int off, int kind);
    req_valid = 1; req_seg = SEG_W'(seg); req_off = OFFSET_W'(off); req_kind = 2'(kind);
  endtask

  task automatic tick();
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: lookup after reset traps on segment number
    put_req(0, 0, 0); tick();
    tick();
    // R10: length 0 keeps everything illegal even with a valid entry
    put_entry(0, 'h100, 16, 1, 7); tick();
    put_req(0, 0, 0); tick();
    // configure length 4, entry 2 read-only
    put_len(4); put_entry(2, 'h1000, 'h100, 1, 1); tick();
    put_entry(5, 'h2000, 'h100, 1, 7); tick();
    put_req(5, 0, 0); tick();          // R3 wins over valid entry
    put_req(3, 0, 0); tick();          // R4 invalid entry
    put_req(2, 'h10, 1); tick();       // R5 write not allowed
    put_req(2, 'h200, 1); tick();      // R5 wins over limit
    put_req(2, 0, 3); tick();          // R5 reserved kind
    put_req(2, 'h100, 0); tick();      // R6 offset == limit
    put_req(2, 'hFF, 0); tick();       // R7 offset == limit-1
    put_req(0, 'h5, 2); tick();        // R7 execute
    // R9: same-cycle write and lookup sees old entry
    put_entry(3, 'h3000, 'h40, 1, 2); put_req(3, 'h8, 1); tick();
    put_req(3, 'h8, 1); tick();
    // R9: length write same cycle
    put_len(16); put_req(15, 0, 0); tick();
    put_entry(15, 'hFFFF0, 'h1000, 1, 1); tick();
    put_req(15, 'hFFF, 0); tick();     // R10 full length, R7 wrap of sum
    tick();                            // R2 idle
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25)
        put_entry($urandom_range(0, SEG_COUNT-1), $urandom, $urandom_range(0, 1 << OFFSET_W),
                  ($urandom_range(0, 3) != 0), $urandom_range(0, 7));
      if (r >= 95) put_len($urandom_range(0, SEG_COUNT));
      if ($urandom_range(0, 9) < 7) begin
        int s;
        int o;
        s = $urandom_range(0, SEG_COUNT-1);
        case ($urandom_range(0, 3))
          0: o = m_lim[s];
          1: o = m_lim[s] - 1;
          default: o = $urandom_range(0, (1 << OFFSET_W) - 1);
        endcase
        if (o < 0) o = 0;
        put_req(s, o, $urandom_range(0, 3));
      end
      tick();
    end
    tick();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R2: watchdog expired, got no end of run, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule